// File: doc/BRIEF.md
# NAND Block-Range Erase Sequencer

This block erases a run of whole erase blocks in a NAND flash device. A client gives it a byte start address and a byte length. The block first checks the request. Both values must fall on an erase-block boundary, and the range must end at or before the last byte of the device. It then reads the device status to confirm that writes are enabled. After that it works through the range one block at a time. For each block it reads the bad-block marker byte from the spare area of the block's first page. A block whose marker is not 0xFF is never erased. For a good block it sends the two-phase erase (setup with a row address, then confirm) and waits for the device to finish.

The block does not drive the flash pins itself. It hands single commands to a command/address sequencer over a hold-until-done handshake. It hands the busy wait to a completion waiter, which returns the final status byte. The first refused, bad or failed block ends the whole range. An abort input lets the block in progress finish and then stops the range.

The state machine has these states: IDLE, CHECK (range verdict), WP_CMD (status read), GATE (range finished, abort, or next block), MARK_CMD (marker read), SETUP_CMD, GO_CMD (erase confirm), WAIT (completion), NEXT (advance cursor) and REPORT (one-cycle result). The transitions are:

- IDLE to CHECK on a request.
- CHECK to WP_CMD if the range is valid, otherwise CHECK to REPORT.
- WP_CMD to GATE if writes are enabled, otherwise WP_CMD to REPORT.
- GATE to REPORT when no length remains or an abort is pending, otherwise GATE to MARK_CMD.
- MARK_CMD to SETUP_CMD on an erased marker, otherwise MARK_CMD to REPORT.
- SETUP_CMD to GO_CMD to WAIT.
- WAIT to NEXT on success, otherwise WAIT to REPORT.
- NEXT to GATE.
- REPORT to IDLE.

Top module: `nand_erase_seq`

## Requirements
- R1: A start address that is not a multiple of the erase-block size produces a failed result and no command at all.
- R2: A length that is not a multiple of the erase-block size produces a failed result and no command at all.
- R3: A range whose start plus length exceeds the device size produces a failed result and no command. A range that ends exactly at the device end is accepted.
- R4: The first command of an accepted request is a status read: opcode 0x70, no column, no row, one byte read back. If bit 7 of that byte (write enable) is 0, the result is failed and no further command follows.
- R5: Each block begins with a spare read: opcode 0x50, column 5, row equal to the block's first page, one byte read back. A byte other than 0xFF gives a failed result with no erase command for that block or any later block.
- R6: A good block is erased with opcode 0x60 carrying only a row address (the block's first page), then opcode 0xD0 with no address, then exactly one completion wait.
- R7: A completion status byte with bit 0 set ends the range with a failed result. No command is issued for later blocks.
- R8: Successive blocks use rows that advance by the pages per block (block size divided by page size). Exactly length divided by block size blocks are processed. Every row sent is a multiple of the pages per block.
- R9: The result is successful only if every block in the range was erased. A zero length is successful after the status read, with no block commands.
- R10: busy rises in the cycle after a request is accepted and stays high through the single cycle in which res_valid is high, then falls. A request made while busy is ignored.
- R11: An abort pulse while busy lets the current block finish its erase and completion wait. The range then stops: failed if blocks remain, successful if none remain.
- R12: After reset, busy, res_valid, res_ok, cmd_valid and wait_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | ADDR_W+1 | Byte length |
| abort_req | input | 1 | Stop after the current block |
| busy | output | 1 | Request in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | Result: 1 = every block erased |
| cmd_valid | output | 1 | Command request, held until cmd_done |
| cmd_opcode | output | 8 | Command opcode |
| cmd_col_en | output | 1 | Column address cycle present |
| cmd_col | output | COL_W | Column address |
| cmd_row_en | output | 1 | Row address cycles present |
| cmd_row | output | ADDR_W-PAGE_SHIFT | Row (page) address, zero when absent |
| cmd_read | output | 1 | One data byte is to be read back |
| cmd_done | input | 1 | Command finished (one-cycle pulse) |
| cmd_rdata | input | 8 | Byte read back, valid with cmd_done |
| wait_valid | output | 1 | Completion wait request, held until wait_done |
| wait_done | input | 1 | Device ready (one-cycle pulse) |
| wait_status | input | 8 | Final status byte, valid with wait_done |

## Verification
The assertions take three things for granted about the inputs:

- cmd_done and wait_done are single-cycle pulses.
- Each pulse arrives only while the matching request is held.
- The length is at most the device size, so the row cursor never runs past a range that the range check has already accepted.

The bench's sequencer and waiter models only answer a request they currently see, and always drop the done pulse after one cycle. Random requests draw block-aligned addresses and lengths of up to four blocks, with occasional misaligned offsets. A request made while busy is issued only as a deliberate test pulse.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WP_CMD,
        ST_GATE,
        ST_MARK_CMD,
        ST_SETUP_CMD,
        ST_GO_CMD,
        ST_WAIT,
        ST_NEXT,
        ST_REPORT
    } erase_state_t;

endpackage

// File: rtl/erase_range_check.sv
module erase_range_check #(
    parameter int ADDR_W      = 24,
    parameter int BLOCK_SHIFT = 14,
    parameter int DEV_BLOCKS  = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   len,
    output logic              range_ok
);
    localparam int SUM_W = ADDR_W + 2;
    localparam logic [SUM_W-1:0] DEV_SIZE = SUM_W'(DEV_BLOCKS) << BLOCK_SHIFT;

    logic [SUM_W-1:0] span_end;
    logic             addr_aligned;
    logic             len_aligned;

    always_comb begin
        span_end     = {2'b00, addr} + {1'b0, len};
        addr_aligned = (addr[BLOCK_SHIFT-1:0] == '0);
        len_aligned  = (len[BLOCK_SHIFT-1:0] == '0);
        range_ok     = addr_aligned && len_aligned && (span_end <= DEV_SIZE);
    end
endmodule

// File: rtl/erase_cursor.sv
module erase_cursor #(
    parameter int ADDR_W      = 24,
    parameter int PAGE_SHIFT  = 9,
    parameter int BLOCK_SHIFT = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ADDR_W:0]            len,
    input  logic                       step,
    output logic [ADDR_W-PAGE_SHIFT-1:0] row,
    output logic                       rem_zero
);
    localparam int ROW_W = ADDR_W - PAGE_SHIFT;
    localparam logic [ROW_W-1:0]  PAGES_PER_BLK = ROW_W'(1) << (BLOCK_SHIFT - PAGE_SHIFT);
    localparam logic [ADDR_W:0]   BLK_BYTES     = (ADDR_W + 1)'(1) << BLOCK_SHIFT;

    logic [ADDR_W:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row   <= '0;
            rem_q <= '0;
        end else if (load) begin
            row   <= ROW_W'(addr >> PAGE_SHIFT);
            rem_q <= len;
        end else if (step) begin
            row   <= row + PAGES_PER_BLK;
            rem_q <= rem_q - BLK_BYTES;
        end
    end

    assign rem_zero = (rem_q == '0);

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_q >= BLK_BYTES));
endmodule

// File: rtl/erase_fsm.sv
module erase_fsm
    import nand_erase_pkg::*;
#(
    parameter int         COL_W          = 8,
    parameter logic [7:0] OP_STATUS      = 8'h70,
    parameter logic [7:0] OP_READ_SPARE  = 8'h50,
    parameter logic [7:0] OP_ERASE_SETUP = 8'h60,
    parameter logic [7:0] OP_ERASE_GO    = 8'h D0,
    parameter int         MARK_COL       = 5,
    parameter logic [7:0] WP_MASK        = 8'h80,
    parameter logic [7:0] FAIL_MASK      = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             range_ok,
    input  logic             rem_zero,
    input  logic             abort_req,
    input  logic             cmd_done,
    input  logic [7:0]       cmd_rdata,
    input  logic             wait_done,
    input  logic [7:0]       wait_status,
    output logic             load,
    output logic             step,
    output logic             busy,
    output logic             res_valid,
    output logic             res_ok,
    output logic             cmd_valid,
    output logic [7:0]       cmd_opcode,
    output logic             cmd_col_en,
    output logic [COL_W-1:0] cmd_col,
    output logic             cmd_row_en,
    output logic             cmd_read,
    output logic             wait_valid
);
    erase_state_t state_q, state_d;
    logic ok_q, ok_d;
    logic chk_q;
    logic abort_q;
    logic wr_enabled;
    logic erase_failed;

    assign wr_enabled   = |(cmd_rdata & WP_MASK);
    assign erase_failed = |(wait_status & FAIL_MASK);

    // state register and per-request flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ok_q    <= 1'b0;
            chk_q   <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ok_q    <= ok_d;
            if (load)
                chk_q <= range_ok;
            if (state_q == ST_IDLE)
                abort_q <= 1'b0;
            else if (abort_req)
                abort_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ok_d    = ok_q;
        unique case (state_q)
            ST_IDLE: begin
                ok_d = 1'b0;
                if (req_valid)
                    state_d = ST_CHECK;
            end
            ST_CHECK: begin
                state_d = chk_q ? ST_WP_CMD : ST_REPORT;
            end
            ST_WP_CMD: begin
                if (cmd_done)
                    state_d = wr_enabled ? ST_GATE : ST_REPORT;
            end
            ST_GATE: begin
                if (rem_zero) begin
                    ok_d    = 1'b1;
                    state_d = ST_REPORT;
                end else if (abort_q) begin
                    state_d = ST_REPORT;
                end else begin
                    state_d = ST_MARK_CMD;
                end
            end
            ST_MARK_CMD: begin
                if (cmd_done)
                    state_d = (cmd_rdata == 8'hFF) ? ST_SETUP_CMD : ST_REPORT;
            end
            ST_SETUP_CMD: begin
                if (cmd_done)
                    state_d = ST_GO_CMD;
            end
            ST_GO_CMD: begin
                if (cmd_done)
                    state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (wait_done)
                    state_d = erase_failed ? ST_REPORT : ST_NEXT;
            end
            ST_NEXT: begin
                state_d = ST_GATE;
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid  = 1'b0;
        cmd_opcode = 8'h00;
        cmd_col_en = 1'b0;
        cmd_col    = '0;
        cmd_row_en = 1'b0;
        cmd_read   = 1'b0;
        wait_valid = 1'b0;
        step       = 1'b0;
        res_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CHECK, ST_GATE: begin
            end
            ST_WP_CMD: begin
                cmd_valid  = 1'b1;
                cmd_opcode = OP_STATUS;
                cmd_read   = 1'b1;
            end
            ST_MARK_CMD: begin
                cmd_valid  = 1'b1;
                cmd_opcode = OP_READ_SPARE;
                cmd_col_en = 1'b1;
                cmd_col    = COL_W'(MARK_COL);
                cmd_row_en = 1'b1;
                cmd_read   = 1'b1;
            end
            ST_SETUP_CMD: begin
                cmd_valid  = 1'b1;
                cmd_opcode = OP_ERASE_SETUP;
                cmd_row_en = 1'b1;
            end
            ST_GO_CMD: begin
                cmd_valid  = 1'b1;
                cmd_opcode = OP_ERASE_GO;
            end
            ST_WAIT: begin
                wait_valid = 1'b1;
            end
            ST_NEXT: begin
                step = 1'b1;
            end
            ST_REPORT: begin
                res_valid = 1'b1;
            end
        endcase
    end

    assign load   = (state_q == ST_IDLE) && req_valid;
    assign busy   = (state_q != ST_IDLE);
    assign res_ok = ok_q && res_valid;

    // R10
    busy_until_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(res_valid));

    // R10
    single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && !busy));

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_opcode)));

    // R6
    one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && wait_valid));

    // R9
    ok_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ok) |-> chk_q);
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq #(
    parameter int         ADDR_W         = 24,
    parameter int         PAGE_SHIFT     = 9,
    parameter int         BLOCK_SHIFT    = 14,
    parameter int         DEV_BLOCKS     = 1024,
    parameter int         COL_W          = 8,
    parameter logic [7:0] OP_STATUS      = 8'h70,
    parameter logic [7:0] OP_READ_SPARE  = 8'h50,
    parameter logic [7:0] OP_ERASE_SETUP = 8'h60,
    parameter logic [7:0] OP_ERASE_GO    = 8'hD0,
    parameter int         MARK_COL       = 5,
    parameter logic [7:0] WP_MASK        = 8'h80,
    parameter logic [7:0] FAIL_MASK      = 8'h01
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [ADDR_W:0]              req_len,
    input  logic                         abort_req,
    output logic                         busy,
    output logic                         res_valid,
    output logic                         res_ok,
    output logic                         cmd_valid,
    output logic [7:0]                   cmd_opcode,
    output logic                         cmd_col_en,
    output logic [COL_W-1:0]             cmd_col,
    output logic                         cmd_row_en,
    output logic [ADDR_W-PAGE_SHIFT-1:0] cmd_row,
    output logic                         cmd_read,
    input  logic                         cmd_done,
    input  logic [7:0]                   cmd_rdata,
    output logic                         wait_valid,
    input  logic                         wait_done,
    input  logic [7:0]                   wait_status
);
    localparam int ROW_W  = ADDR_W - PAGE_SHIFT;
    localparam int PPB_SH = BLOCK_SHIFT - PAGE_SHIFT;

    logic             range_ok;
    logic             rem_zero;
    logic             load;
    logic             step;
    logic [ROW_W-1:0] cur_row;

    erase_range_check #(
        .ADDR_W      (ADDR_W),
        .BLOCK_SHIFT (BLOCK_SHIFT),
        .DEV_BLOCKS  (DEV_BLOCKS)
    ) u_range (
        .addr     (req_addr),
        .len      (req_len),
        .range_ok (range_ok)
    );

    erase_cursor #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .BLOCK_SHIFT (BLOCK_SHIFT)
    ) u_cursor (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .addr     (req_addr),
        .len      (req_len),
        .step     (step),
        .row      (cur_row),
        .rem_zero (rem_zero)
    );

    erase_fsm #(
        .COL_W          (COL_W),
        .OP_STATUS      (OP_STATUS),
        .OP_READ_SPARE  (OP_READ_SPARE),
        .OP_ERASE_SETUP (OP_ERASE_SETUP),
        .OP_ERASE_GO    (OP_ERASE_GO),
        .MARK_COL       (MARK_COL),
        .WP_MASK        (WP_MASK),
        .FAIL_MASK      (FAIL_MASK)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .range_ok    (range_ok),
        .rem_zero    (rem_zero),
        .abort_req   (abort_req),
        .cmd_done    (cmd_done),
        .cmd_rdata   (cmd_rdata),
        .wait_done   (wait_done),
        .wait_status (wait_status),
        .load        (load),
        .step        (step),
        .busy        (busy),
        .res_valid   (res_valid),
        .res_ok      (res_ok),
        .cmd_valid   (cmd_valid),
        .cmd_opcode  (cmd_opcode),
        .cmd_col_en  (cmd_col_en),
        .cmd_col     (cmd_col),
        .cmd_row_en  (cmd_row_en),
        .cmd_read    (cmd_read),
        .wait_valid  (wait_valid)
    );

    assign cmd_row = cmd_row_en ? cur_row : '0;

    // R8
    row_block_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_row_en) |-> (cmd_row[PPB_SH-1:0] == '0));

    // R5
    no_erase_while_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || wait_valid) |-> busy);
endmodule

// File: tb/nand_erase_seq_bench.sv
module nand_erase_seq_bench;
    localparam int ADDR_W      = 16;
    localparam int PAGE_SHIFT  = 9;
    localparam int BLOCK_SHIFT = 12;
    localparam int DEV_BLOCKS  = 12;
    localparam int ROW_W       = ADDR_W - PAGE_SHIFT;
    localparam int PPB         = 1 << (BLOCK_SHIFT - PAGE_SHIFT);
    localparam int BS          = 1 << BLOCK_SHIFT;
    localparam int DEV_BYTES   = DEV_BLOCKS * BS;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [ADDR_W:0]   req_len;
    logic              abort_req;
    logic              busy, res_valid, res_ok;
    logic              cmd_valid, cmd_col_en, cmd_row_en, cmd_read;
    logic [7:0]        cmd_opcode;
    logic [7:0]        cmd_col;
    logic [ROW_W-1:0]  cmd_row;
    logic              cmd_done;
    logic [7:0]        cmd_rdata;
    logic              wait_valid, wait_done;
    logic [7:0]        wait_status;

    nand_erase_seq #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .BLOCK_SHIFT (BLOCK_SHIFT),
        .DEV_BLOCKS  (DEV_BLOCKS)
    ) u_nand_erase_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .abort_req(abort_req), .busy(busy),
        .res_valid(res_valid), .res_ok(res_ok), .cmd_valid(cmd_valid),
        .cmd_opcode(cmd_opcode), .cmd_col_en(cmd_col_en), .cmd_col(cmd_col),
        .cmd_row_en(cmd_row_en), .cmd_row(cmd_row), .cmd_read(cmd_read),
        .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .wait_valid(wait_valid),
        .wait_done(wait_done), .wait_status(wait_status)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;
    logic [39:0] got_log [64];
    int          got_n;
    logic [39:0] exp_log [64];
    int          exp_n;
    bit          exp_ok;
    logic [7:0]  marker [DEV_BLOCKS];
    bit          efail  [DEV_BLOCKS];
    bit          wp_en;
    int          abort_at;
    int          blk_seq;
    int          cur_blk;

    function automatic logic [39:0] ent(input logic [7:0] op, input bit ce, input bit re,
                                        input bit rd, input int col, input int row);
        return {5'b0, op, ce, re, rd, 8'(col), 16'(row)};
    endfunction

    task automatic chk(input bit pass, input string tag, input string detail);
        n_chk++;
        if (!pass) begin
            n_bad++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // command sequencer and completion waiter model
    initial begin
        cmd_done = 0; wait_done = 0; cmd_rdata = 0; wait_status = 0; abort_req = 0;
        got_n = 0; cur_blk = 0; blk_seq = 0;
        forever begin
            @(negedge clk);
            if (rst_n && cmd_valid) begin
                if (got_n < 64) begin
                    got_log[got_n] = ent(cmd_opcode, cmd_col_en, cmd_row_en, cmd_read,
                                         cmd_col_en ? int'(cmd_col) : 0,
                                         cmd_row_en ? int'(cmd_row) : 0);
                    got_n++;
                end
                if (cmd_opcode == 8'h50)
                    cur_blk = int'(cmd_row) / PPB;
                repeat ($urandom_range(3, 0)) @(negedge clk);
                if (cmd_opcode == 8'h70)
                    cmd_rdata = (wp_en ? 8'h80 : 8'h00) | 8'(($urandom() & 32'h7F));
                else if (cmd_opcode == 8'h50)
                    cmd_rdata = (cur_blk < DEV_BLOCKS) ? marker[cur_blk] : 8'hFF;
                else
                    cmd_rdata = 8'($urandom());
                cmd_done = 1;
                @(negedge clk);
                cmd_done = 0;
            end else if (rst_n && wait_valid) begin
                if (got_n < 64) begin
                    got_log[got_n] = ent(8'h00, 0, 0, 0, 0, 0);
                    got_n++;
                end
                if (blk_seq == abort_at) abort_req = 1;
                blk_seq++;
                repeat ($urandom_range(3, 0)) @(negedge clk);
                wait_status = (cur_blk < DEV_BLOCKS && efail[cur_blk]) ? 8'h41 : 8'h40;
                wait_done = 1;
                @(negedge clk);
                wait_done = 0;
                abort_req = 0;
            end
        end
    end

    task automatic device_clean();
        for (int b = 0; b < DEV_BLOCKS; b++) begin
            marker[b] = 8'hFF;
            efail[b]  = 0;
        end
        wp_en    = 1;
        abort_at = -1;
    endtask

    task automatic exp_push(input logic [39:0] e);
        if (exp_n < 64) exp_log[exp_n] = e;
        exp_n++;
    endtask

    task automatic exp_build(input int addr, input int len);
        int blk, nb, row;
        exp_n  = 0;
        exp_ok = 0;
        if ((addr % BS) != 0 || (len % BS) != 0 || addr + len > DEV_BYTES) return;
        exp_push(ent(8'h70, 0, 0, 1, 0, 0));
        if (!wp_en) return;
        blk = addr / BS;
        nb  = len / BS;
        for (int i = 0; i <= nb; i++) begin
            if (i == nb) begin
                exp_ok = 1;
                return;
            end
            if (abort_at >= 0 && abort_at < i) return;
            row = (blk + i) * PPB;
            exp_push(ent(8'h50, 1, 1, 1, 5, row));
            if (marker[blk + i] != 8'hFF) return;
            exp_push(ent(8'h60, 0, 1, 0, 0, row));
            exp_push(ent(8'hD0, 0, 0, 0, 0, 0));
            exp_push(ent(8'h00, 0, 0, 0, 0, 0));
            if (efail[blk + i]) return;
        end
    endtask

    task automatic run_op(input int addr, input int len, input string tag, input bit poke);
        int  cyc;
        bit  seen;
        bit  log_ok;
        int  bad_i;
        exp_build(addr, len);
        got_n   = 0;
        blk_seq = 0;
        @(negedge clk);
        req_valid = 1;
        req_addr  = ADDR_W'(addr);
        req_len   = (ADDR_W + 1)'(len);
        @(negedge clk);
        req_valid = 0;
        req_addr  = '0;
        req_len   = '0;
        chk(busy === 1'b1, "R10", $sformatf("%s busy after accept got %b exp 1", tag, busy));
        seen = 0;
        cyc  = 0;
        while (!seen && cyc < 3000) begin
            if (res_valid === 1'b1) begin
                seen = 1;
            end else begin
                if (poke && cyc == 2) begin
                    req_valid = 1;
                    req_addr  = ADDR_W'(BS);
                    req_len   = (ADDR_W + 1)'(BS);
                end else begin
                    req_valid = 0;
                end
                @(negedge clk);
                cyc++;
            end
        end
        req_valid = 0;
        chk(seen, tag, $sformatf("result strobe seen got %b exp 1", seen));
        chk(res_ok === exp_ok, tag, $sformatf("addr %0d len %0d res_ok got %b exp %b",
                                              addr, len, res_ok, exp_ok));
        log_ok = (got_n == exp_n);
        bad_i  = -1;
        for (int i = 0; i < exp_n && i < 64; i++)
            if (log_ok && got_log[i] !== exp_log[i]) begin
                log_ok = 0;
                bad_i  = i;
            end
        if (bad_i >= 0)
            chk(0, tag, $sformatf("addr %0d len %0d entry %0d got %h exp %h",
                                  addr, len, bad_i, got_log[bad_i], exp_log[bad_i]));
        else
            chk(log_ok, tag, $sformatf("addr %0d len %0d command count got %0d exp %0d",
                                       addr, len, got_n, exp_n));
        @(negedge clk);
        chk(busy === 1'b0 && res_valid === 1'b0, "R10",
            $sformatf("%s after result busy %b res_valid %b exp 0 0", tag, busy, res_valid));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got hang exp finish");
        summary();
    end

    initial begin
        int a, l;
        void'($urandom(32'd20240611));
        rst_n = 0; req_valid = 0; req_addr = '0; req_len = '0;
        device_clean();
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(busy === 0 && res_valid === 0 && res_ok === 0 && cmd_valid === 0 && wait_valid === 0,
            "R12", $sformatf("reset outputs got %b%b%b%b%b exp 00000",
                             busy, res_valid, res_ok, cmd_valid, wait_valid));

        device_clean(); run_op(BS + 512, BS, "R1", 0);
        device_clean(); run_op(2 * BS, BS + 1, "R2", 0);
        device_clean(); run_op(10 * BS, 3 * BS, "R3", 0);
        device_clean(); run_op(10 * BS, 2 * BS, "R3", 0);
        device_clean(); wp_en = 0; run_op(0, 2 * BS, "R4", 0);
        device_clean(); run_op(3 * BS, 0, "R9", 0);
        device_clean(); marker[3] = 8'h00; run_op(2 * BS, 4 * BS, "R5", 0);
        device_clean(); marker[6] = 8'hFE; run_op(6 * BS, BS, "R5", 0);
        device_clean(); efail[1] = 1; run_op(0, 3 * BS, "R7", 0);
        device_clean(); run_op(4 * BS, 4 * BS, "R6 R8", 0);
        device_clean(); run_op(0, DEV_BYTES, "R8", 0);
        device_clean(); abort_at = 1; run_op(0, 4 * BS, "R11", 0);
        device_clean(); abort_at = 1; run_op(5 * BS, 2 * BS, "R11", 0);
        device_clean(); run_op(7 * BS, 3 * BS, "R10", 1);

        for (int n = 0; n < 40; n++) begin
            device_clean();
            for (int b = 0; b < DEV_BLOCKS; b++) begin
                if ($urandom_range(9, 0) == 0) marker[b] = 8'($urandom_range(254, 0));
                if ($urandom_range(9, 0) == 0) efail[b] = 1;
            end
            wp_en = ($urandom_range(9, 0) != 0);
            if ($urandom_range(4, 0) == 0) abort_at = $urandom_range(3, 0);
            a = $urandom_range(DEV_BLOCKS - 1, 0) * BS;
            l = $urandom_range(4, 0) * BS;
            if ($urandom_range(9, 0) == 0) a = a + $urandom_range(BS - 1, 1);
            if ($urandom_range(9, 0) == 0) l = l + $urandom_range(BS - 1, 1);
            run_op(a, l, "R5 R6 R7 R8 R9", 0);
        end

        summary();
    end
endmodule